// File: doc/BRIEF.md
# Layered Bus Address Decoder

This block sits between a simple processor bus and a set of memory and peripheral targets: four flash banks, two SRAM banks, two memory-mapped UART register blocks and two I/O-space register blocks. A request (address, read and write strobes, write data and an I/O-space qualifier) is captured in a register stage. A tree of small combinational decoders then works on the captured request. The first layer looks only at the top address nibble and picks a region. Each deeper layer decodes only the few bits it needs, and only while its parent's enable is high. The tree drives exactly one target select together with that target's trimmed local offset.

Read data from the selected target is steered back to the processor through a multiplexer keyed by the same decode. Write data and shared read and write strobes go to all targets, but only the selected one sees its select high. An address that lands in no mapped range produces a one-cycle error with no select and zero read data. The I/O qualifier behaves as if it forced address bit 31 high. Peripheral addresses issued with it therefore reach the I/O register blocks instead of the UARTs, through the same lower address bits.

Top module: `addr_tree_decoder`

## Requirements
- R1: The region is chosen from address bits 31:28, with bit 31 taken as (address bit 31 OR req_io): 0x0 is flash, 0x2 is SRAM, 0x4 is the memory peripheral region, 0xC is the I/O peripheral region, and every other value is unmapped.
- R2: In the flash region, bits 13:12 pick flash_sel bit 0..3, flash_off carries bits 11:0, and any set bit in 27:14 makes the access unmapped.
- R3: In the SRAM region, bit 13 picks sram_sel bit 0 or 1, sram_off carries bits 12:0, and any set bit in 27:14 makes the access unmapped.
- R4: In the memory peripheral region, bits 27:24 must equal 1 and bits 23:20 equal 1 or 2 to raise uart_sel bit 0 or 1, and uart_off carries bits 19:0 unchanged. Group values other than 1, and instance values 0 or 3 and above, are unmapped.
- R5: In the I/O peripheral region the same group and instance rules raise iore_sel bit 0 or 1 with iore_off set to bits 19:0, and uart_sel stays low.
- R6: An unmapped valid request raises rsp_err for exactly the one cycle in which that request is decoded. In that cycle no select is high, rsp_rdata is zero and neither tgt_rd nor tgt_wr is high.
- R7: Selects follow a request by one clock: a request captured at an edge drives its select until the next edge. At most one select bit is high in any cycle, and none is high in a cycle with no captured request.
- R8: rsp_rdata equals the selected target's read data while tgt_rd is high, and is zero otherwise.
- R9: While rst_n is low, all selects, rsp_err, tgt_rd and tgt_wr are low whatever the request inputs are.
- R10: tgt_wr is high only in a cycle with a selected target and a captured write. tgt_wdata then carries that write's data, and tgt_rd stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_io | input | 1 | I/O-space qualifier |
| req_rd | input | 1 | Read strobe |
| req_wr | input | 1 | Write strobe |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data steered from the selected target |
| rsp_err | output | 1 | Unmapped-access error pulse |
| tgt_rd | output | 1 | Read strobe toward targets |
| tgt_wr | output | 1 | Write strobe toward targets |
| tgt_wdata | output | 32 | Write data toward targets |
| flash_sel | output | 4 | Flash bank selects |
| flash_off | output | 12 | Flash in-bank offset |
| flash_rdata | input | 128 | Flash bank read data, bank k at bits 32k+31:32k |
| sram_sel | output | 2 | SRAM bank selects |
| sram_off | output | 13 | SRAM in-bank offset |
| sram_rdata | input | 64 | SRAM bank read data |
| uart_sel | output | 2 | Memory-mapped UART selects |
| uart_off | output | 20 | UART register offset |
| uart_rdata | input | 64 | UART read data |
| iore_sel | output | 2 | I/O-space register block selects |
| iore_off | output | 20 | I/O register offset |
| iore_rdata | input | 64 | I/O register block read data |

## Verification
The hardest case to reach is one where the same low address bits must land on different targets depending on the I/O qualifier. A second such case is one where a nearly valid address fails at a deep layer only: UART group correct but instance 0 or 3, or flash with a stray bit above the bank field. The stimulus table therefore pairs identical lower bits with and without req_io, and with address bit 31 set directly. It also probes the address just past each range end. Requests are issued back to back so that every edge carries a new decode, and an error request is followed by an idle cycle to show the error lasts only one cycle.

// File: rtl/atd_pkg.sv
package atd_pkg;

   // Region chosen by the first decode layer
   typedef enum logic [2:0] {
      RG_NONE,
      RG_FLASH,
      RG_SRAM,
      RG_MEM_PERI,
      RG_IO_PERI
   } region_e;

   localparam logic [3:0] NIB_FLASH    = 4'h0;
   localparam logic [3:0] NIB_SRAM     = 4'h2;
   localparam logic [3:0] NIB_MEM_PERI = 4'h4;
   localparam logic [3:0] NIB_IO_PERI  = 4'hC;

   // Peripheral sub-space: group field 27:24, instance field 23:20, offset 19:0
   localparam int PERI_OFF_W  = 20;
   localparam int REGION_LO   = 28;

   typedef struct packed {
      logic valid;
      logic io;
      logic rd;
      logic wr;
   } req_ctrl_t;

endpackage

// File: rtl/atd_req_stage.sv
module atd_req_stage
   import atd_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  req_ctrl_t         ctrl_in,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic [DATA_W-1:0] wdata_in,
   output req_ctrl_t         ctrl_q,
   output logic [ADDR_W-1:0] addr_q,
   output logic [DATA_W-1:0] wdata_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q  <= '0;
         addr_q  <= '0;
         wdata_q <= '0;
      end else begin
         ctrl_q  <= ctrl_in;
         addr_q  <= addr_in;
         wdata_q <= wdata_in;
      end
   end

endmodule

// File: rtl/atd_region_dec.sv
module atd_region_dec
   import atd_pkg::*;
(
   input  logic     en,
   input  logic     io,
   input  logic [3:0] nibble,
   output region_e  region
);

   logic [3:0] eff_nib;

   always_comb begin
      eff_nib = {nibble[3] | io, nibble[2:0]};
      region  = RG_NONE;
      if (en) begin
         case (eff_nib)
            NIB_FLASH:    region = RG_FLASH;
            NIB_SRAM:     region = RG_SRAM;
            NIB_MEM_PERI: region = RG_MEM_PERI;
            NIB_IO_PERI:  region = RG_IO_PERI;
            default:      region = RG_NONE;
         endcase
      end
   end

endmodule

// File: rtl/atd_bank_dec.sv
module atd_bank_dec #(
   parameter int BANKS  = 4,
   parameter int OFF_W  = 12,
   parameter int SPAN_W = 28
) (
   input  logic              en,
   input  logic [SPAN_W-1:0] field,
   output logic [BANKS-1:0]  sel,
   output logic [OFF_W-1:0]  off,
   output logic              hit
);

   localparam int BANK_W = $clog2(BANKS);
   localparam int USED_W = OFF_W + BANK_W;

   logic              upper_clear;
   logic [BANK_W-1:0] bank;

   generate
      if (BANKS < 2 || (1 << BANK_W) != BANKS) begin : g_bad_banks
         $error("atd_bank_dec: BANKS must be a power of two of at least 2");
      end
      if (USED_W > SPAN_W) begin : g_bad_span
         $error("atd_bank_dec: bank and offset fields exceed the region span");
      end
      if (USED_W < SPAN_W) begin : g_upper
         assign upper_clear = (field[SPAN_W-1:USED_W] == '0);
      end else begin : g_full
         assign upper_clear = 1'b1;
      end
   endgenerate

   assign hit  = en & upper_clear;
   assign bank = field[USED_W-1:OFF_W];
   assign off  = hit ? field[OFF_W-1:0] : '0;

   generate
      for (genvar k = 0; k < BANKS; k++) begin : g_sel
         assign sel[k] = hit & (bank == BANK_W'(k));
      end
   endgenerate

endmodule

// File: rtl/atd_periph_dec.sv
module atd_periph_dec
   import atd_pkg::*;
#(
   parameter int          COUNT    = 2,
   parameter logic [3:0]  GROUP_ID = 4'h1
) (
   input  logic                  en,
   input  logic [3:0]            group,
   input  logic [3:0]            inst,
   input  logic [PERI_OFF_W-1:0] off_in,
   output logic [COUNT-1:0]      sel,
   output logic [PERI_OFF_W-1:0] off,
   output logic                  hit
);

   logic grp_en;

   generate
      if (COUNT < 1 || COUNT > 14) begin : g_bad_count
         $error("atd_periph_dec: COUNT must lie in 1..14");
      end
   endgenerate

   // Second layer: group; third layer: instance, gated by the group enable
   assign grp_en = en & (group == GROUP_ID);

   generate
      for (genvar k = 0; k < COUNT; k++) begin : g_inst
         assign sel[k] = grp_en & (inst == 4'(k + 1));
      end
   endgenerate

   assign hit = |sel;
   assign off = hit ? off_in : '0;

endmodule

// File: rtl/atd_rdata_mux.sv
module atd_rdata_mux #(
   parameter int DATA_W   = 32,
   parameter int N        = 10,
   parameter bit AND_OR   = 1'b1
) (
   input  logic [N-1:0]        sel,
   input  logic [N*DATA_W-1:0] data,
   input  logic                rd_en,
   output logic [DATA_W-1:0]   dout
);

   logic [DATA_W-1:0] acc;

   generate
      if (AND_OR) begin : g_andor
         always_comb begin
            acc = '0;
            for (int k = 0; k < N; k++)
               acc = acc | ({DATA_W{sel[k]}} & data[k*DATA_W +: DATA_W]);
         end
      end else begin : g_prio
         always_comb begin
            acc = '0;
            for (int k = N - 1; k >= 0; k--)
               if (sel[k]) acc = data[k*DATA_W +: DATA_W];
         end
      end
   endgenerate

   assign dout = rd_en ? acc : '0;

endmodule

// File: rtl/addr_tree_decoder.sv
module addr_tree_decoder
   import atd_pkg::*;
#(
   parameter int DATA_W       = 32,
   parameter int FLASH_BANKS  = 4,
   parameter int FLASH_OFF_W  = 12,
   parameter int SRAM_BANKS   = 2,
   parameter int SRAM_OFF_W   = 13,
   parameter int UART_COUNT   = 2,
   parameter logic [3:0] UART_GROUP = 4'h1,
   parameter bit RD_AND_OR    = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          req_valid,
   input  logic                          req_io,
   input  logic                          req_rd,
   input  logic                          req_wr,
   input  logic [31:0]                   req_addr,
   input  logic [DATA_W-1:0]             req_wdata,
   output logic [DATA_W-1:0]             rsp_rdata,
   output logic                          rsp_err,
   output logic                          tgt_rd,
   output logic                          tgt_wr,
   output logic [DATA_W-1:0]             tgt_wdata,
   output logic [FLASH_BANKS-1:0]        flash_sel,
   output logic [FLASH_OFF_W-1:0]        flash_off,
   input  logic [FLASH_BANKS*DATA_W-1:0] flash_rdata,
   output logic [SRAM_BANKS-1:0]         sram_sel,
   output logic [SRAM_OFF_W-1:0]         sram_off,
   input  logic [SRAM_BANKS*DATA_W-1:0]  sram_rdata,
   output logic [UART_COUNT-1:0]         uart_sel,
   output logic [PERI_OFF_W-1:0]         uart_off,
   input  logic [UART_COUNT*DATA_W-1:0]  uart_rdata,
   output logic [UART_COUNT-1:0]         iore_sel,
   output logic [PERI_OFF_W-1:0]         iore_off,
   input  logic [UART_COUNT*DATA_W-1:0]  iore_rdata
);

   localparam int N_TGT = FLASH_BANKS + SRAM_BANKS + 2 * UART_COUNT;

   generate
      if (DATA_W < 8) begin : g_bad_dw
         $error("addr_tree_decoder: DATA_W too small");
      end
   endgenerate

   req_ctrl_t         ctrl_in, rq;
   logic [31:0]       raddr;
   logic [DATA_W-1:0] rwdata;
   region_e           region;
   logic              flash_hit, sram_hit, uart_hit, iore_hit, any_hit;
   logic [N_TGT-1:0]  all_sel;
   logic              any_sel;

   assign ctrl_in = '{valid: req_valid, io: req_io, rd: req_rd, wr: req_wr};

   atd_req_stage #(.ADDR_W(32), .DATA_W(DATA_W)) u_stage (
      .clk      (clk),
      .rst_n    (rst_n),
      .ctrl_in  (ctrl_in),
      .addr_in  (req_addr),
      .wdata_in (req_wdata),
      .ctrl_q   (rq),
      .addr_q   (raddr),
      .wdata_q  (rwdata)
   );

   // Layer one: region from the top nibble
   atd_region_dec u_region (
      .en     (rq.valid),
      .io     (rq.io),
      .nibble (raddr[31:REGION_LO]),
      .region (region)
   );

   // Layer two: memory banks
   atd_bank_dec #(.BANKS(FLASH_BANKS), .OFF_W(FLASH_OFF_W), .SPAN_W(REGION_LO)) u_flash (
      .en    (region == RG_FLASH),
      .field (raddr[REGION_LO-1:0]),
      .sel   (flash_sel),
      .off   (flash_off),
      .hit   (flash_hit)
   );

   atd_bank_dec #(.BANKS(SRAM_BANKS), .OFF_W(SRAM_OFF_W), .SPAN_W(REGION_LO)) u_sram (
      .en    (region == RG_SRAM),
      .field (raddr[REGION_LO-1:0]),
      .sel   (sram_sel),
      .off   (sram_off),
      .hit   (sram_hit)
   );

   // Layers two and three: peripheral group and instance, once per space
   atd_periph_dec #(.COUNT(UART_COUNT), .GROUP_ID(UART_GROUP)) u_uart (
      .en     (region == RG_MEM_PERI),
      .group  (raddr[27:24]),
      .inst   (raddr[23:20]),
      .off_in (raddr[PERI_OFF_W-1:0]),
      .sel    (uart_sel),
      .off    (uart_off),
      .hit    (uart_hit)
   );

   atd_periph_dec #(.COUNT(UART_COUNT), .GROUP_ID(UART_GROUP)) u_iore (
      .en     (region == RG_IO_PERI),
      .group  (raddr[27:24]),
      .inst   (raddr[23:20]),
      .off_in (raddr[PERI_OFF_W-1:0]),
      .sel    (iore_sel),
      .off    (iore_off),
      .hit    (iore_hit)
   );

   assign all_sel = {iore_sel, uart_sel, sram_sel, flash_sel};
   assign any_hit = flash_hit | sram_hit | uart_hit | iore_hit;
   assign any_sel = |all_sel;

   atd_rdata_mux #(.DATA_W(DATA_W), .N(N_TGT), .AND_OR(RD_AND_OR)) u_rmux (
      .sel   (all_sel),
      .data  ({iore_rdata, uart_rdata, sram_rdata, flash_rdata}),
      .rd_en (rq.rd & any_sel),
      .dout  (rsp_rdata)
   );

   assign rsp_err   = rq.valid & ~any_hit;
   assign tgt_rd    = rq.rd & any_sel;
   assign tgt_wr    = rq.wr & ~rq.rd & any_sel;
   assign tgt_wdata = rwdata;

endmodule

// File: rtl/atd_checker.sv
module atd_checker #(
   parameter int DATA_W      = 32,
   parameter int FLASH_BANKS = 4,
   parameter int SRAM_BANKS  = 2,
   parameter int UART_COUNT  = 2
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   req_valid,
   input logic                   req_io,
   input logic                   req_wr,
   input logic [31:0]            req_addr,
   input logic [DATA_W-1:0]      rsp_rdata,
   input logic                   rsp_err,
   input logic                   tgt_rd,
   input logic                   tgt_wr,
   input logic [FLASH_BANKS-1:0] flash_sel,
   input logic [SRAM_BANKS-1:0]  sram_sel,
   input logic [UART_COUNT-1:0]  uart_sel,
   input logic [UART_COUNT-1:0]  iore_sel
);

   logic [FLASH_BANKS+SRAM_BANKS+2*UART_COUNT-1:0] sels;
   assign sels = {iore_sel, uart_sel, sram_sel, flash_sel};

   p_onehot_sel_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sels));

   p_sel_needs_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (|sels) |-> $past(req_valid));

   p_err_needs_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> $past(req_valid));

   p_err_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> (sels == '0 && rsp_rdata == '0 && !tgt_rd && !tgt_wr));

   p_uart_not_io_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (|uart_sel) |-> !$past(req_io));

   p_iore_space_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (|iore_sel) |-> ($past(req_io) || $past(req_addr[31])));

   p_rdata_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !tgt_rd |-> (rsp_rdata == '0));

   p_write_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
      tgt_wr |-> ((|sels) && $past(req_wr) && !tgt_rd));

   // R9: reset holds the outputs quiet
   always @(negedge clk) begin
      if (!rst_n) begin
         p_reset_quiet_r9: assert (sels == '0 && !rsp_err && !tgt_rd && !tgt_wr);
      end
   end

endmodule

bind addr_tree_decoder atd_checker #(
   .DATA_W(DATA_W), .FLASH_BANKS(FLASH_BANKS), .SRAM_BANKS(SRAM_BANKS), .UART_COUNT(UART_COUNT)
) u_atd_checker (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_io(req_io), .req_wr(req_wr),
   .req_addr(req_addr), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .tgt_rd(tgt_rd),
   .tgt_wr(tgt_wr), .flash_sel(flash_sel), .sram_sel(sram_sel), .uart_sel(uart_sel),
   .iore_sel(iore_sel)
);

// File: tb/tb_addr_tree_decoder.sv
module tb_addr_tree_decoder;

   localparam int CLK_PERIOD = 10;
   localparam int DW = 32;

   // vector: io, address, expected target code {class,index}, expected offset
   // class 0 = unmapped, 1 = flash, 2 = SRAM, 3 = UART, 4 = I/O block
   typedef struct packed {
      logic        io;
      logic [31:0] addr;
      logic [7:0]  code;
      logic [19:0] off;
   } vec_t;

   localparam int NV = 24;
   localparam vec_t VECS [NV] = '{
      {1'b0, 32'h0000_0000, 8'h10, 20'h00000},
      {1'b0, 32'h0000_0FFF, 8'h10, 20'h00FFF},
      {1'b0, 32'h0000_1000, 8'h11, 20'h00000},
      {1'b0, 32'h0000_2345, 8'h12, 20'h00345},
      {1'b0, 32'h0000_3ABC, 8'h13, 20'h00ABC},
      {1'b0, 32'h0000_4000, 8'h00, 20'h00000},
      {1'b0, 32'h0100_0000, 8'h00, 20'h00000},
      {1'b0, 32'h2000_0000, 8'h20, 20'h00000},
      {1'b0, 32'h2000_1FFF, 8'h20, 20'h01FFF},
      {1'b0, 32'h2000_2000, 8'h21, 20'h00000},
      {1'b0, 32'h2000_3FFF, 8'h21, 20'h01FFF},
      {1'b0, 32'h2000_4000, 8'h00, 20'h00000},
      {1'b0, 32'h4110_0123, 8'h30, 20'h00123},
      {1'b0, 32'h4120_0123, 8'h31, 20'h00123},
      {1'b0, 32'h411F_FFFF, 8'h30, 20'hFFFFF},
      {1'b0, 32'h4130_0123, 8'h00, 20'h00000},
      {1'b0, 32'h4100_0123, 8'h00, 20'h00000},
      {1'b0, 32'h4210_0123, 8'h00, 20'h00000},
      {1'b1, 32'h4110_0123, 8'h40, 20'h00123},
      {1'b1, 32'h4120_0FFF, 8'h41, 20'h00FFF},
      {1'b0, 32'hC110_0123, 8'h40, 20'h00123},
      {1'b1, 32'h0000_0010, 8'h00, 20'h00000},
      {1'b0, 32'h1000_0000, 8'h00, 20'h00000},
      {1'b0, 32'h5FFF_FFFF, 8'h00, 20'h00000}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0, req_io = 1'b0, req_rd = 1'b0, req_wr = 1'b0;
   logic [31:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic [DW-1:0] rsp_rdata, tgt_wdata;
   logic rsp_err, tgt_rd, tgt_wr;
   logic [3:0]  flash_sel;
   logic [11:0] flash_off;
   logic [127:0] flash_rdata;
   logic [1:0]  sram_sel;
   logic [12:0] sram_off;
   logic [63:0] sram_rdata;
   logic [1:0]  uart_sel;
   logic [19:0] uart_off;
   logic [63:0] uart_rdata;
   logic [1:0]  iore_sel;
   logic [19:0] iore_off;
   logic [63:0] iore_rdata;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   addr_tree_decoder dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_io(req_io),
      .req_rd(req_rd), .req_wr(req_wr), .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .tgt_rd(tgt_rd), .tgt_wr(tgt_wr),
      .tgt_wdata(tgt_wdata), .flash_sel(flash_sel), .flash_off(flash_off),
      .flash_rdata(flash_rdata), .sram_sel(sram_sel), .sram_off(sram_off),
      .sram_rdata(sram_rdata), .uart_sel(uart_sel), .uart_off(uart_off),
      .uart_rdata(uart_rdata), .iore_sel(iore_sel), .iore_off(iore_off),
      .iore_rdata(iore_rdata)
   );

   // Target stubs: data word = {class, index, 4'h0, offset}
   always_comb begin
      for (int k = 0; k < 4; k++)
         flash_rdata[k*32 +: 32] = {4'h1, 4'(k), 4'h0, 8'h00, flash_off};
      for (int k = 0; k < 2; k++) begin
         sram_rdata[k*32 +: 32] = {4'h2, 4'(k), 4'h0, 7'h00, sram_off};
         uart_rdata[k*32 +: 32] = {4'h3, 4'(k), 4'h0, uart_off};
         iore_rdata[k*32 +: 32] = {4'h4, 4'(k), 4'h0, iore_off};
      end
   end

   task automatic chk(input string req, input string what, input logic [63:0] act,
                      input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] seen_code();
      logic [7:0] c = 8'h00;
      for (int k = 0; k < 4; k++) if (flash_sel[k]) c = {4'h1, 4'(k)};
      for (int k = 0; k < 2; k++) begin
         if (sram_sel[k]) c = {4'h2, 4'(k)};
         if (uart_sel[k]) c = {4'h3, 4'(k)};
         if (iore_sel[k]) c = {4'h4, 4'(k)};
      end
      return c;
   endfunction

   function automatic logic [19:0] seen_off(input logic [3:0] cls);
      case (cls)
         4'h1:    return 20'(flash_off);
         4'h2:    return 20'(sram_off);
         4'h3:    return uart_off;
         4'h4:    return iore_off;
         default: return 20'h0;
      endcase
   endfunction

   function automatic string tag(input logic [3:0] cls);
      case (cls)
         4'h1:    return "R1 R2";
         4'h2:    return "R1 R3";
         4'h3:    return "R1 R4";
         4'h4:    return "R1 R5";
         default: return "R1 R6";
      endcase
   endfunction

   function automatic int nsel();
      return $countones({iore_sel, uart_sel, sram_sel, flash_sel});
   endfunction

   task automatic drive(input logic io, input logic [31:0] a, input logic rd,
                        input logic wr, input logic [31:0] wd);
      @(negedge clk);
      req_valid = 1'b1; req_io = io; req_addr = a; req_rd = rd; req_wr = wr; req_wdata = wd;
      @(posedge clk);
      #2;
   endtask

   initial begin
      #(CLK_PERIOD * 5000);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      // R9: request presented while reset is held
      req_valid = 1'b1; req_rd = 1'b1; req_addr = 32'h0000_1000;
      repeat (3) @(posedge clk);
      #2;
      chk("R9", "selects in reset", 64'(nsel()), 64'd0);
      chk("R9", "err/strobes in reset", {61'd0, rsp_err, tgt_rd, tgt_wr}, 64'd0);
      @(negedge clk);
      req_valid = 1'b0; req_rd = 1'b0;
      rst_n = 1'b1;

      // Table sweep, back-to-back reads
      for (int i = 0; i < NV; i++) begin
         logic [31:0] exp_d;
         drive(VECS[i].io, VECS[i].addr, 1'b1, 1'b0, '0);
         exp_d = (VECS[i].code == 8'h00) ? 32'h0 : {VECS[i].code, 4'h0, VECS[i].off};
         chk(tag(VECS[i].code[7:4]), $sformatf("target @%h", VECS[i].addr),
             64'(seen_code()), 64'(VECS[i].code));
         chk("R7", "select count", 64'(nsel()), (VECS[i].code == 8'h00) ? 64'd0 : 64'd1);
         chk(tag(VECS[i].code[7:4]), "offset", 64'(seen_off(VECS[i].code[7:4])),
             64'(VECS[i].off));
         chk("R8", "read data", 64'(rsp_rdata), 64'(exp_d));
         chk("R6", "error flag", 64'(rsp_err), (VECS[i].code == 8'h00) ? 64'd1 : 64'd0);
      end

      // R6 R7: idle after an error request clears everything
      @(negedge clk);
      req_valid = 1'b0; req_rd = 1'b0;
      @(posedge clk);
      #2;
      chk("R6", "error after idle", 64'(rsp_err), 64'd0);
      chk("R7", "selects after idle", 64'(nsel()), 64'd0);

      // R10 R8: write to SRAM bank 1
      drive(1'b0, 32'h2000_2010, 1'b0, 1'b1, 32'hCAFE_0001);
      chk("R10", "sram select on write", 64'(sram_sel), 64'h2);
      chk("R10", "write strobe", {62'd0, tgt_wr, tgt_rd}, 64'h2);
      chk("R10", "write data", 64'(tgt_wdata), 64'hCAFE_0001);
      chk("R8", "rdata on write", 64'(rsp_rdata), 64'd0);

      // R10 R6: write to an unmapped UART index
      drive(1'b0, 32'h4130_0000, 1'b0, 1'b1, 32'h1234_5678);
      chk("R10", "no write strobe unmapped", 64'(tgt_wr), 64'd0);
      chk("R6", "error on unmapped write", 64'(rsp_err), 64'd1);

      // R7: valid without read or write still selects but strobes stay low
      drive(1'b0, 32'h0000_0004, 1'b0, 1'b0, '0);
      chk("R7", "select without strobe", 64'(flash_sel), 64'h1);
      chk("R8", "no read strobe", {62'd0, tgt_rd, tgt_wr}, 64'd0);

      @(negedge clk);
      req_valid = 1'b0; req_wr = 1'b0;
      @(posedge clk);
      #2;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule